// File: doc/BRIEF.md
# DMA Channel Register File

This block is the host-facing register file of a four-channel DMA controller. A processor reaches it through an 8-bit read/write port addressed by a 4-bit offset. For each channel it keeps a 16-bit start address, a running address, a start count and a running count. Because the port is only one byte wide, each 16-bit value is moved one byte at a time. A single byte-pointer flip-flop, shared by all channels, decides which half an access touches.

Alongside the per-channel values it holds the controller-wide command, request, status and temporary bytes, a 4-bit channel mask and one mode byte per channel. Several write-only offsets act as strobes: they clear the byte pointer, clear the mask, or perform a soft master reset. A separate transfer engine, outside this block, reads every register through flat output buses. It writes back running address and count, status and temporary values through a small update port. A host write to a channel register in the same cycle as an engine update takes precedence.

Top module: `dmaHostRegs`

## Requirements
- R1: Even offsets 0, 2, 4, 6 reach the address register of channels 0 to 3, and odd offsets 1, 3, 5, 7 reach their count registers. A read returns one byte of the running value. A write stores the data byte into the same half of both the start and the running copy.
- R2: The byte pointer selects bits 7:0 when it is 0 and bits 15:8 when it is 1. It is shared by all channels, and it toggles on every read or write at offsets 0 to 7.
- R3: A write of any value to offset 0xC returns the byte pointer to 0. A read of 0xC leaves it unchanged.
- R4: A write to offset 0xB stores a mode byte for the channel named by data bits 1:0. The stored value is the data with bits 1:0 forced to 0, and the other channels keep their mode.
- R5: A write to offset 0xA changes one mask bit, for the channel named by data bits 1:0. Data bit 2 = 1 sets that bit and data bit 2 = 0 clears it.
- R6: A write to offset 0xF loads the mask from data bits 3:0. A read of 0xF returns the mask in bits 3:0, with bits 7:4 at 0.
- R7: A write to offset 0xD clears the command, request, status and temporary registers and the byte pointer, and sets the mask to 0xF. It leaves the address, count and mode registers unchanged. A read of 0xD returns the temporary register.
- R8: A write to offset 0xE clears all four mask bits.
- R9: A read of offset 0x8 returns the status register, and a write to 0x8 loads the command register. A write to 0x9 loads the request register.
- R10: Reads of offsets 0x9, 0xA, 0xB, 0xC and 0xE return 0x00.
- R11: Hardware reset (rstN low) clears every register and the byte pointer, and sets the mask to 0xF.
- R12: An engine update loads the running address and count of the selected channel and leaves the start copies unchanged. If the host writes that channel's address or count register in the same cycle, the host byte is stored and the engine value for that register is dropped.
- R13: The engine status and temporary write enables load the status and temporary registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low hardware reset |
| hostSel | input | 1 | Host access valid this cycle |
| hostWr | input | 1 | 1 = write, 0 = read |
| hostOff | input | 4 | Register offset |
| hostWrData | input | 8 | Host write byte |
| hostRdData | output | 8 | Host read byte, combinational during the access cycle |
| engUpdValid | input | 1 | Engine updates running address and count |
| engUpdChan | input | 2 | Channel being updated |
| engUpdAddr | input | 16 | New running address |
| engUpdCount | input | 16 | New running count |
| engStatusWe | input | 1 | Engine status write enable |
| engStatusData | input | 8 | New status value |
| engTempWe | input | 1 | Engine temporary write enable |
| engTempData | input | 8 | New temporary value |
| baseAddrBus | output | 64 | Start addresses, channel n in bits 16n+15:16n |
| curAddrBus | output | 64 | Running addresses, same packing |
| baseCountBus | output | 64 | Start counts, same packing |
| curCountBus | output | 64 | Running counts, same packing |
| modeBus | output | 32 | Mode bytes, channel n in bits 8n+7:8n |
| cmdOut | output | 8 | Command register |
| reqOut | output | 8 | Request register |
| maskOut | output | 4 | Channel mask, bit n for channel n |

## Verification
On every cycle, the assertions check the byte pointer's toggling and clearing. They check that a host byte lands in both the start and running copies even when the engine updates the same channel. They also check the cleared low bits of stored modes, single-bit mask changes, and the mask values after a mask clear or master reset. The bench scenarios cover what needs a history of accesses. These are the 16-bit round trips through two byte accesses, and the sharing of one byte pointer across channels. They also include the read-back of status, temporary and mask through their offsets, zero reads from write-only offsets, and the registers that a master reset must leave intact.

// File: rtl/dmaRegPkg.sv
package dmaRegPkg;
  localparam int NUM_CH  = 4;
  localparam int CH_BITS = $clog2(NUM_CH);

  localparam logic [3:0] OFF_CMD_STAT = 4'h8;
  localparam logic [3:0] OFF_REQ      = 4'h9;
  localparam logic [3:0] OFF_MASK_ONE = 4'hA;
  localparam logic [3:0] OFF_MODE     = 4'hB;
  localparam logic [3:0] OFF_PTR_CLR  = 4'hC;
  localparam logic [3:0] OFF_MRST_TMP = 4'hD;
  localparam logic [3:0] OFF_MASK_CLR = 4'hE;
  localparam logic [3:0] OFF_MASK_ALL = 4'hF;

  typedef enum logic [2:0] {
    RD_NONE, RD_ADDR, RD_COUNT, RD_STATUS, RD_TEMP, RD_MASK
  } rdSel_e;

  typedef struct packed {
    logic               wrAddr;
    logic               wrCount;
    logic               wrCmd;
    logic               wrReq;
    logic               wrMode;
    logic               wrMaskOne;
    logic               wrMaskAll;
    logic               clrMask;
    logic               masterRst;
    logic               hiByte;
    logic [CH_BITS-1:0] chan;
    rdSel_e             rdSel;
  } regStrobes_t;
endpackage

// File: rtl/dmaRegCtrl.sv
module dmaRegCtrl
  import dmaRegPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               hostSel,
  input  logic               hostWr,
  input  logic [3:0]         hostOff,
  input  logic [CH_BITS-1:0] chanData,
  output regStrobes_t        strb
);
  logic byteFf;
  logic chanAccess;
  logic ptrClear;

  assign chanAccess = hostSel && !hostOff[3];
  assign ptrClear   = hostSel && hostWr &&
                      (hostOff == OFF_PTR_CLR || hostOff == OFF_MRST_TMP);

  always_comb begin
    strb        = '0;
    strb.hiByte = byteFf;
    strb.chan   = hostOff[CH_BITS:1];
    strb.rdSel  = RD_NONE;
    if (hostSel) begin
      if (!hostOff[3]) begin
        if (hostWr) begin
          strb.wrAddr  = !hostOff[0];
          strb.wrCount = hostOff[0];
        end else begin
          strb.rdSel = hostOff[0] ? RD_COUNT : RD_ADDR;
        end
      end else begin
        case (hostOff)
          OFF_CMD_STAT: if (hostWr) strb.wrCmd = 1'b1; else strb.rdSel = RD_STATUS;
          OFF_REQ:      strb.wrReq = hostWr;
          OFF_MASK_ONE: begin strb.wrMaskOne = hostWr; strb.chan = chanData; end
          OFF_MODE:     begin strb.wrMode = hostWr; strb.chan = chanData; end
          OFF_MRST_TMP: if (hostWr) strb.masterRst = 1'b1; else strb.rdSel = RD_TEMP;
          OFF_MASK_CLR: strb.clrMask = hostWr;
          OFF_MASK_ALL: if (hostWr) strb.wrMaskAll = 1'b1; else strb.rdSel = RD_MASK;
          default:      strb.rdSel = RD_NONE;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)           byteFf <= 1'b0;
    else if (ptrClear)   byteFf <= 1'b0;
    else if (chanAccess) byteFf <= ~byteFf;
  end

  // R2: every channel-register access flips the byte pointer
  assert_ptr_toggle_R2: assert property (@(posedge clk) disable iff (!rstN)
    chanAccess |=> (byteFf != $past(byteFf)));

  // R3: pointer clear and master reset leave the pointer at the low byte
  assert_ptr_clear_R3: assert property (@(posedge clk) disable iff (!rstN)
    ptrClear |=> !byteFf);
endmodule

// File: rtl/dmaRegData.sv
module dmaRegData
  import dmaRegPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  regStrobes_t                strb,
  input  logic [DATA_W-1:0]          hostWrData,
  output logic [DATA_W-1:0]          hostRdData,
  input  logic                       engUpdValid,
  input  logic [CH_BITS-1:0]         engUpdChan,
  input  logic [2*DATA_W-1:0]        engUpdAddr,
  input  logic [2*DATA_W-1:0]        engUpdCount,
  input  logic                       engStatusWe,
  input  logic [DATA_W-1:0]          engStatusData,
  input  logic                       engTempWe,
  input  logic [DATA_W-1:0]          engTempData,
  output logic [NUM_CH*2*DATA_W-1:0] baseAddrBus,
  output logic [NUM_CH*2*DATA_W-1:0] curAddrBus,
  output logic [NUM_CH*2*DATA_W-1:0] baseCountBus,
  output logic [NUM_CH*2*DATA_W-1:0] curCountBus,
  output logic [NUM_CH*DATA_W-1:0]   modeBus,
  output logic [DATA_W-1:0]          cmdOut,
  output logic [DATA_W-1:0]          reqOut,
  output logic [NUM_CH-1:0]          maskOut
);
  localparam int REG_W = 2 * DATA_W;

  logic [REG_W-1:0]  baseAddrQ  [NUM_CH];
  logic [REG_W-1:0]  curAddrQ   [NUM_CH];
  logic [REG_W-1:0]  baseCountQ [NUM_CH];
  logic [REG_W-1:0]  curCountQ  [NUM_CH];
  logic [DATA_W-1:0] modeQ      [NUM_CH];
  logic [DATA_W-1:0] cmdQ, reqQ, statusQ, tempQ;
  logic [NUM_CH-1:0] maskQ;
  logic              loSel;

  assign loSel = !strb.hiByte;

  for (genvar c = 0; c < NUM_CH; c++) begin : gChan
    logic hitAddr, hitCount, hitMode, engHit;
    assign hitAddr  = strb.wrAddr  && (strb.chan == c);
    assign hitCount = strb.wrCount && (strb.chan == c);
    assign hitMode  = strb.wrMode  && (strb.chan == c);
    assign engHit   = engUpdValid  && (engUpdChan == c);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        baseAddrQ[c]  <= '0;
        curAddrQ[c]   <= '0;
        baseCountQ[c] <= '0;
        curCountQ[c]  <= '0;
        modeQ[c]      <= '0;
      end else begin
        if (hitAddr) begin
          baseAddrQ[c][strb.hiByte*DATA_W +: DATA_W] <= hostWrData;
          curAddrQ[c][strb.hiByte*DATA_W +: DATA_W]  <= hostWrData;
        end else if (engHit) begin
          curAddrQ[c] <= engUpdAddr;
        end
        if (hitCount) begin
          baseCountQ[c][strb.hiByte*DATA_W +: DATA_W] <= hostWrData;
          curCountQ[c][strb.hiByte*DATA_W +: DATA_W]  <= hostWrData;
        end else if (engHit) begin
          curCountQ[c] <= engUpdCount;
        end
        if (hitMode) modeQ[c] <= {hostWrData[DATA_W-1:2], 2'b00};
      end
    end

    assign baseAddrBus[c*REG_W +: REG_W]  = baseAddrQ[c];
    assign curAddrBus[c*REG_W +: REG_W]   = curAddrQ[c];
    assign baseCountBus[c*REG_W +: REG_W] = baseCountQ[c];
    assign curCountBus[c*REG_W +: REG_W]  = curCountQ[c];
    assign modeBus[c*DATA_W +: DATA_W]    = modeQ[c];

    // R1 and R12: a host byte reaches both copies, even against an engine update
    assert_addr_lo_both_R12: assert property (@(posedge clk) disable iff (!rstN)
      (hitAddr && loSel) |=> (curAddrQ[c][DATA_W-1:0] == $past(hostWrData) &&
                              baseAddrQ[c][DATA_W-1:0] == $past(hostWrData)));
    assert_count_hi_both_R1: assert property (@(posedge clk) disable iff (!rstN)
      (hitCount && !loSel) |=> (curCountQ[c][REG_W-1:DATA_W] == $past(hostWrData) &&
                                baseCountQ[c][REG_W-1:DATA_W] == $past(hostWrData)));
    // R4: stored mode never keeps the channel-select bits
    assert_mode_low_clear_R4: assert property (@(posedge clk) disable iff (!rstN)
      hitMode |=> (modeQ[c][1:0] == 2'b00));
    // R5: single-channel mask write follows data bit 2
    assert_mask_one_R5: assert property (@(posedge clk) disable iff (!rstN)
      (strb.wrMaskOne && strb.chan == c && !strb.masterRst) |=>
        (maskQ[c] == $past(hostWrData[2])));
  end

  always_ff @(posedge clk) begin
    if (!rstN || strb.masterRst) begin
      cmdQ    <= '0;
      reqQ    <= '0;
      statusQ <= '0;
      tempQ   <= '0;
      maskQ   <= '1;
    end else begin
      if (strb.wrCmd)  cmdQ    <= hostWrData;
      if (strb.wrReq)  reqQ    <= hostWrData;
      if (engStatusWe) statusQ <= engStatusData;
      if (engTempWe)   tempQ   <= engTempData;
      if (strb.clrMask)        maskQ <= '0;
      else if (strb.wrMaskAll) maskQ <= hostWrData[NUM_CH-1:0];
      else if (strb.wrMaskOne) maskQ[strb.chan] <= hostWrData[2];
    end
  end

  always_comb begin
    case (strb.rdSel)
      RD_ADDR:   hostRdData = curAddrQ[strb.chan][strb.hiByte*DATA_W +: DATA_W];
      RD_COUNT:  hostRdData = curCountQ[strb.chan][strb.hiByte*DATA_W +: DATA_W];
      RD_STATUS: hostRdData = statusQ;
      RD_TEMP:   hostRdData = tempQ;
      RD_MASK:   hostRdData = {{(DATA_W-NUM_CH){1'b0}}, maskQ};
      default:   hostRdData = '0;
    endcase
  end

  assign cmdOut  = cmdQ;
  assign reqOut  = reqQ;
  assign maskOut = maskQ;

  // R7: master reset leaves every channel masked and the control bytes cleared
  assert_master_reset_R7: assert property (@(posedge clk) disable iff (!rstN)
    strb.masterRst |=> (maskQ == '1 && cmdQ == '0 && reqQ == '0 &&
                        statusQ == '0 && tempQ == '0));
  // R8: mask clear empties the mask
  assert_mask_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clrMask && !strb.masterRst) |=> (maskQ == '0));
endmodule

// File: rtl/dmaHostRegs.sv
module dmaHostRegs
  import dmaRegPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       hostSel,
  input  logic                       hostWr,
  input  logic [3:0]                 hostOff,
  input  logic [DATA_W-1:0]          hostWrData,
  output logic [DATA_W-1:0]          hostRdData,
  input  logic                       engUpdValid,
  input  logic [CH_BITS-1:0]         engUpdChan,
  input  logic [2*DATA_W-1:0]        engUpdAddr,
  input  logic [2*DATA_W-1:0]        engUpdCount,
  input  logic                       engStatusWe,
  input  logic [DATA_W-1:0]          engStatusData,
  input  logic                       engTempWe,
  input  logic [DATA_W-1:0]          engTempData,
  output logic [NUM_CH*2*DATA_W-1:0] baseAddrBus,
  output logic [NUM_CH*2*DATA_W-1:0] curAddrBus,
  output logic [NUM_CH*2*DATA_W-1:0] baseCountBus,
  output logic [NUM_CH*2*DATA_W-1:0] curCountBus,
  output logic [NUM_CH*DATA_W-1:0]   modeBus,
  output logic [DATA_W-1:0]          cmdOut,
  output logic [DATA_W-1:0]          reqOut,
  output logic [NUM_CH-1:0]          maskOut
);
  regStrobes_t strb;

  dmaRegCtrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .hostSel  (hostSel),
    .hostWr   (hostWr),
    .hostOff  (hostOff),
    .chanData (hostWrData[CH_BITS-1:0]),
    .strb     (strb)
  );

  dmaRegData #(.DATA_W(DATA_W)) uData (
    .clk           (clk),
    .rstN          (rstN),
    .strb          (strb),
    .hostWrData    (hostWrData),
    .hostRdData    (hostRdData),
    .engUpdValid   (engUpdValid),
    .engUpdChan    (engUpdChan),
    .engUpdAddr    (engUpdAddr),
    .engUpdCount   (engUpdCount),
    .engStatusWe   (engStatusWe),
    .engStatusData (engStatusData),
    .engTempWe     (engTempWe),
    .engTempData   (engTempData),
    .baseAddrBus   (baseAddrBus),
    .curAddrBus    (curAddrBus),
    .baseCountBus  (baseCountBus),
    .curCountBus   (curCountBus),
    .modeBus       (modeBus),
    .cmdOut        (cmdOut),
    .reqOut        (reqOut),
    .maskOut       (maskOut)
  );
endmodule

// File: tb/sim_dmaHostRegs.sv
`timescale 1ns/1ps
module sim_dmaHostRegs;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostSel = 1'b0, hostWr = 1'b0;
  logic [3:0]  hostOff = '0;
  logic [7:0]  hostWrData = '0;
  logic [7:0]  hostRdData;
  logic        engUpdValid = 1'b0;
  logic [1:0]  engUpdChan = '0;
  logic [15:0] engUpdAddr = '0, engUpdCount = '0;
  logic        engStatusWe = 1'b0, engTempWe = 1'b0;
  logic [7:0]  engStatusData = '0, engTempData = '0;
  logic [63:0] baseAddrBus, curAddrBus, baseCountBus, curCountBus;
  logic [31:0] modeBus;
  logic [7:0]  cmdOut, reqOut;
  logic [3:0]  maskOut;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  dmaHostRegs u0 (.*);

  // vector: {write, offset, data, expected read, requirement number}
  localparam int NV = 30;
  localparam logic [24:0] VEC [NV] = '{
    {1'b1, 4'hC, 8'h00, 8'h00, 4'd3},   // R3 pointer to low byte
    {1'b1, 4'h2, 8'h34, 8'h00, 4'd1},   // R1 ch1 address low
    {1'b1, 4'h2, 8'h12, 8'h00, 4'd1},   // R1 ch1 address high
    {1'b0, 4'h2, 8'h00, 8'h34, 4'd1},
    {1'b0, 4'h2, 8'h00, 8'h12, 4'd1},
    {1'b1, 4'h7, 8'hCD, 8'h00, 4'd1},   // R1 ch3 count
    {1'b1, 4'h7, 8'hAB, 8'h00, 4'd1},
    {1'b0, 4'h7, 8'h00, 8'hCD, 4'd1},
    {1'b0, 4'h7, 8'h00, 8'hAB, 4'd1},
    {1'b1, 4'h4, 8'h55, 8'h00, 4'd2},   // R2 pointer now high
    {1'b1, 4'hC, 8'h00, 8'h00, 4'd3},   // R3 clear pointer
    {1'b0, 4'h4, 8'h00, 8'h55, 4'd3},
    {1'b0, 4'h2, 8'h00, 8'h12, 4'd2},   // R2 shared pointer, high of ch1
    {1'b0, 4'hF, 8'h00, 8'h0F, 4'd11},  // R11 mask after reset
    {1'b1, 4'hE, 8'h00, 8'h00, 4'd8},   // R8
    {1'b0, 4'hF, 8'h00, 8'h00, 4'd8},
    {1'b1, 4'hA, 8'h06, 8'h00, 4'd5},   // R5 mask ch2
    {1'b0, 4'hF, 8'h00, 8'h04, 4'd5},
    {1'b1, 4'hA, 8'h07, 8'h00, 4'd5},   // R5 mask ch3
    {1'b0, 4'hF, 8'h00, 8'h0C, 4'd5},
    {1'b1, 4'hA, 8'h02, 8'h00, 4'd5},   // R5 unmask ch2
    {1'b0, 4'hF, 8'h00, 8'h08, 4'd5},
    {1'b1, 4'hF, 8'hA5, 8'h00, 4'd6},   // R6 load mask
    {1'b0, 4'hF, 8'h00, 8'h05, 4'd6},
    {1'b0, 4'h9, 8'h00, 8'h00, 4'd10},  // R10 write-only offsets
    {1'b0, 4'hA, 8'h00, 8'h00, 4'd10},
    {1'b0, 4'hB, 8'h00, 8'h00, 4'd10},
    {1'b0, 4'hE, 8'h00, 8'h00, 4'd10},
    {1'b0, 4'h8, 8'h00, 8'h00, 4'd9},   // R9 status after reset
    {1'b0, 4'hC, 8'h00, 8'h00, 4'd10}
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [3:0] off, input logic [7:0] d,
                        output logic [7:0] rd);
    @(negedge clk);
    hostSel = 1'b1; hostWr = wr; hostOff = off; hostWrData = d;
    #1 rd = hostRdData;
    @(posedge clk);
    #1 hostSel = 1'b0; hostWr = 1'b0;
  endtask

  task automatic finishRun;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      finishRun();
    end
  end

  initial begin
    logic [7:0] rd;
    repeat (3) @(posedge clk);
    #1;
    check("R11 reset mask", maskOut, 4'hF);
    check("R11 reset addresses", curAddrBus, 64'h0);
    check("R11 reset command", cmdOut, 8'h00);
    @(negedge clk) rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      access(VEC[i][24], VEC[i][23:20], VEC[i][19:12], rd);
      if (!VEC[i][24]) begin
        total++;
        if (rd !== VEC[i][11:4]) begin
          bad++;
          $display("FAIL R%0d vector %0d off=%0h actual=%0h expected=%0h",
                   VEC[i][3:0], i, VEC[i][23:20], rd, VEC[i][11:4]);
        end
      end
    end

    // R4 mode writes
    access(1'b1, 4'hB, 8'hCB, rd);
    access(1'b1, 4'hB, 8'h71, rd);
    check("R4 mode ch3", modeBus[31:24], 8'hC8);
    check("R4 mode ch1", modeBus[15:8], 8'h70);
    check("R4 mode ch0 untouched", modeBus[7:0], 8'h00);

    // R9 command and request
    access(1'b1, 4'h8, 8'h14, rd);
    check("R9 command", cmdOut, 8'h14);
    access(1'b0, 4'h8, 8'h00, rd);
    check("R9 status read not command", rd, 8'h00);
    access(1'b1, 4'h9, 8'h06, rd);
    check("R9 request", reqOut, 8'h06);

    // R13 engine status and temporary
    @(negedge clk);
    engStatusWe = 1'b1; engStatusData = 8'h21; engTempWe = 1'b1; engTempData = 8'h77;
    @(negedge clk);
    engStatusWe = 1'b0; engTempWe = 1'b0;
    access(1'b0, 4'h8, 8'h00, rd);
    check("R13 status", rd, 8'h21);
    access(1'b0, 4'hD, 8'h00, rd);
    check("R13 temp via R7 read", rd, 8'h77);

    // R12 engine update
    @(negedge clk);
    engUpdValid = 1'b1; engUpdChan = 2'd1; engUpdAddr = 16'h4000; engUpdCount = 16'h0010;
    @(negedge clk);
    engUpdValid = 1'b0;
    check("R12 running addr", curAddrBus[31:16], 16'h4000);
    check("R12 start addr kept", baseAddrBus[31:16], 16'h1234);
    check("R12 running count", curCountBus[31:16], 16'h0010);

    // R12 host wins against a simultaneous engine update (pointer is low)
    @(negedge clk);
    hostSel = 1'b1; hostWr = 1'b1; hostOff = 4'h2; hostWrData = 8'h99;
    engUpdValid = 1'b1; engUpdChan = 2'd1; engUpdAddr = 16'h7777; engUpdCount = 16'h0020;
    @(posedge clk);
    #1 hostSel = 1'b0; hostWr = 1'b0; engUpdValid = 1'b0;
    check("R12 host wins addr", curAddrBus[31:16], 16'h4099);
    check("R12 start addr byte", baseAddrBus[31:16], 16'h1299);
    check("R12 count from engine", curCountBus[31:16], 16'h0020);

    // R7 master reset (pointer is high now)
    access(1'b1, 4'hD, 8'h5A, rd);
    check("R7 command cleared", cmdOut, 8'h00);
    check("R7 request cleared", reqOut, 8'h00);
    check("R7 mask set", maskOut, 4'hF);
    access(1'b0, 4'h8, 8'h00, rd);
    check("R7 status cleared", rd, 8'h00);
    access(1'b0, 4'hD, 8'h00, rd);
    check("R7 temp cleared", rd, 8'h00);
    access(1'b1, 4'h6, 8'h11, rd);
    check("R7 pointer cleared", curAddrBus[63:48], 16'h0011);
    check("R7 address kept", curAddrBus[31:16], 16'h4099);
    check("R7 mode kept", modeBus[31:24], 8'hC8);

    // R11 hardware reset mid-run
    @(negedge clk) rstN = 1'b0;
    @(negedge clk);
    check("R11 addresses cleared", curAddrBus, 64'h0);
    check("R11 counts cleared", baseCountBus, 64'h0);
    check("R11 modes cleared", modeBus, 32'h0);
    check("R11 mask set", maskOut, 4'hF);
    rstN = 1'b1;

    finishRun();
  end
endmodule